// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block turns the filtered levels of a bank of input pins into interrupt requests. Each pin normally raises a request on any change, rising or falling. For each pin, software can switch on an extended trigger mode. In that mode the pin responds to only one condition, chosen from four: a rising edge, a falling edge, a high level or a low level. Two pairs of set-style registers make the choice. One pair chooses between edge and level. The other pair chooses between rising/high and falling/low.

Requests collect in a pending register. Reading the status location returns the pending bits and clears them. A mask register, also built from set/clear locations, selects which pending bits drive the single combined interrupt output. Software reaches all configuration through a simple synchronous register port. Every register write and every read takes one clock edge, and read data appears on the cycle after the read strobe.

Top module: `pin_irq_detect`

## Requirements
- R1: After a synchronous reset, the following are all zero: the mask, the extended-mode enables, the edge/level selection (0 = edge), the polarity selection (0 = falling/low), the pending bits, `irq_o` and `rd_data_o`.
- R2: A pin whose extended mode is off sets its pending bit on both rising and falling edges. An edge is the current input compared with its value one cycle earlier.
- R3: A write to 0x40 sets the mask bits that are 1 in the data. A write to 0x44 clears them; writing all ones clears every bit. A read of 0x48 returns the mask.
- R4: A write to 0x b0 turns on extended mode for the pins whose data bits are 1. A write to 0xb4 turns it off. A read of 0xb8 returns the enables.
- R5: A write to 0xc0 selects edge detection for the flagged pins. A write to 0xc4 selects level detection. A read of 0xc8 returns 1 for each pin in level mode.
- R6: A write to 0xd0 selects falling/low polarity for the flagged pins. A write to 0xd4 selects rising/high polarity. A read of 0xd8 returns 1 for each pin set to rising/high.
- R7: A pin in extended edge mode sets its pending bit only on the selected edge. The opposite edge has no effect.
- R8: A pin in extended level mode sets its pending bit on every cycle that its input matches the selected level. The bit is therefore set again right after a status read while the level persists.
- R9: A read of 0x4c returns the pending bits and clears them. An event in the same cycle as the read stays pending and is not part of the returned value.
- R10: `irq_o` goes high one cycle after any pending bit is high while its mask bit is set. Pending bits still latch while masked.
- R11: Read data is registered and appears one cycle after `rd_en_i`. Reads of any other address, including the write-only locations, return zero. Only a read of 0x4c changes the pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | Filtered pin levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Register byte address |
| wr_data_i | input | NPIN | Write data, one bit per pin |
| rd_data_o | output | NPIN | Registered read data |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
An input event and a status read of the same pin can fall in the same cycle. Since the read clears the pending bits, the event must survive the clear and must not appear in the returned value. The bench provokes this directly by toggling a pin on the exact cycle of a status read, and again by holding a level-mode pin active across reads. The random phase mixes pin flips with status reads at a high rate. A bench model predicts each read value and the combined output cycle by cycle. It gives set priority over clear, so a lost or early-reported event shows up as a mismatch.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam logic [7:0] OFS_MSK_SET  = 8'h40;
  localparam logic [7:0] OFS_MSK_CLR  = 8'h44;
  localparam logic [7:0] OFS_MSK_RD   = 8'h48;
  localparam logic [7:0] OFS_PEND_RD  = 8'h4c;
  localparam logic [7:0] OFS_XEN_SET  = 8'hb0;
  localparam logic [7:0] OFS_XEN_CLR  = 8'hb4;
  localparam logic [7:0] OFS_XEN_RD   = 8'hb8;
  localparam logic [7:0] OFS_EDGE_SEL = 8'hc0;
  localparam logic [7:0] OFS_LVL_SEL  = 8'hc4;
  localparam logic [7:0] OFS_KIND_RD  = 8'hc8;
  localparam logic [7:0] OFS_FALL_SEL = 8'hd0;
  localparam logic [7:0] OFS_RISE_SEL = 8'hd4;
  localparam logic [7:0] OFS_POL_RD   = 8'hd8;

  typedef enum logic [1:0] {
    TRIG_ANY_EDGE = 2'd0,
    TRIG_ONE_EDGE = 2'd1,
    TRIG_LEVEL    = 2'd2
  } trig_kind_e;
endpackage

// File: rtl/pid_setclr_reg.sv
module pid_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_en) q <= q | wd;
    else if (clr_en) q <= q & ~wd;
  end

  // R3, R4, R5, R6: set location makes the flagged bits 1
  a_r4_set_sticks: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((q & $past(wd)) == $past(wd)));
  // R3: clearing with all ones empties the register
  a_r3_clear_all: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en && wd == '1) |=> (q == '0));
endmodule

// File: rtl/pid_trig_detect.sv
module pid_trig_detect
  import pid_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] xen_i,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] pol_i,
  output logic [NPIN-1:0] evt_o
);
  logic [NPIN-1:0] prev_q;

  // previous level tracks the input during reset too, so no false edge on release
  always_ff @(posedge clk) prev_q <= pin_i;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    trig_kind_e kind;
    logic rise, fall;

    always_comb begin
      rise = pin_i[i] & ~prev_q[i];
      fall = ~pin_i[i] & prev_q[i];
      if (!xen_i[i])     kind = TRIG_ANY_EDGE;
      else if (lvl_i[i]) kind = TRIG_LEVEL;
      else               kind = TRIG_ONE_EDGE;
      case (kind)
        TRIG_ANY_EDGE: evt_o[i] = rise | fall;
        TRIG_ONE_EDGE: evt_o[i] = pol_i[i] ? rise : fall;
        TRIG_LEVEL:    evt_o[i] = rst ? 1'b0 : (pol_i[i] ? pin_i[i] : ~pin_i[i]);
        default:       evt_o[i] = 1'b0;
      endcase
    end

    // R7: falling-only pin never fires while its input is high
    a_r7_no_wrong_edge: assert property (@(posedge clk) disable iff (rst)
      (xen_i[i] && !lvl_i[i] && !pol_i[i] && pin_i[i]) |-> !evt_o[i]);
  end
endmodule

// File: rtl/pid_pend_store.sv
module pid_pend_store #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] set_i,
  input  logic            clr_i,
  input  logic [NPIN-1:0] mask_i,
  output logic [NPIN-1:0] pend_o,
  output logic            irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= (clr_i ? '0 : pend_o) | set_i;
      irq_o  <= |(pend_o & mask_i);
    end
  end

  // R9: a new event survives a clearing read in the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
  // R9: read with no new event empties the pending bits
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i == '0) |=> (pend_o == '0));
  // R10: nothing pending under the mask means no request next cycle
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    ((pend_o & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pid_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wr_data_i,
  output logic [NPIN-1:0] rd_data_o,
  output logic            irq_o
);
  localparam int NREG = 4;  // mask, extended enable, level kind, polarity
  localparam int R_MSK = 0, R_XEN = 1, R_LVL = 2, R_POL = 3;

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  logic [NREG-1:0]  set_en, clr_en;
  logic [NPIN-1:0]  cfg_q [NREG];
  logic [NPIN-1:0]  evt, pend;
  logic             rd_pend;
  logic [NPIN-1:0]  rd_mux;

  always_comb begin
    set_en[R_MSK] = wr_en_i && hit(addr_i, OFS_MSK_SET);
    clr_en[R_MSK] = wr_en_i && hit(addr_i, OFS_MSK_CLR);
    set_en[R_XEN] = wr_en_i && hit(addr_i, OFS_XEN_SET);
    clr_en[R_XEN] = wr_en_i && hit(addr_i, OFS_XEN_CLR);
    set_en[R_LVL] = wr_en_i && hit(addr_i, OFS_LVL_SEL);
    clr_en[R_LVL] = wr_en_i && hit(addr_i, OFS_EDGE_SEL);
    set_en[R_POL] = wr_en_i && hit(addr_i, OFS_RISE_SEL);
    clr_en[R_POL] = wr_en_i && hit(addr_i, OFS_FALL_SEL);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_cfg
    pid_setclr_reg #(.W(NPIN)) u_reg (
      .clk(clk), .rst(rst), .set_en(set_en[r]), .clr_en(clr_en[r]),
      .wd(wr_data_i), .q(cfg_q[r])
    );
  end

  pid_trig_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .xen_i(cfg_q[R_XEN]), .lvl_i(cfg_q[R_LVL]), .pol_i(cfg_q[R_POL]),
    .evt_o(evt)
  );

  assign rd_pend = rd_en_i && hit(addr_i, OFS_PEND_RD);

  pid_pend_store #(.NPIN(NPIN)) u_pend (
    .clk(clk), .rst(rst), .set_i(evt), .clr_i(rd_pend),
    .mask_i(cfg_q[R_MSK]), .pend_o(pend), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if      (hit(addr_i, OFS_MSK_RD))  rd_mux = cfg_q[R_MSK];
    else if (hit(addr_i, OFS_PEND_RD)) rd_mux = pend;
    else if (hit(addr_i, OFS_XEN_RD))  rd_mux = cfg_q[R_XEN];
    else if (hit(addr_i, OFS_KIND_RD)) rd_mux = cfg_q[R_LVL];
    else if (hit(addr_i, OFS_POL_RD))  rd_mux = cfg_q[R_POL];
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
    else              rd_data_o <= '0;
  end

  // R8: an active high level always leaves the pin pending
  for (genvar i = 0; i < NPIN; i++) begin : g_lvl_chk
    a_r8_level_high: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[R_XEN][i] && cfg_q[R_LVL][i] && cfg_q[R_POL][i] && pin_i[i]) |=> pend[i]);
  end

  // R11: unmapped read returns zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !hit(addr_i, OFS_MSK_RD) && !hit(addr_i, OFS_PEND_RD) &&
     !hit(addr_i, OFS_XEN_RD) && !hit(addr_i, OFS_KIND_RD) && !hit(addr_i, OFS_POL_RD))
    |=> (rd_data_o == '0));
endmodule

// File: tb/pin_irq_detect_tb.sv
module pin_irq_detect_tb;
  localparam int NPIN = 32;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NPIN-1:0] pin_i = '0;
  logic            wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [NPIN-1:0] wr_data_i = '0;
  logic [NPIN-1:0] rd_data_o;
  logic            irq_o;

  always #2 clk = ~clk;  // 250 MHz

  pin_irq_detect #(.NPIN(NPIN), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model of the requirements
  logic [NPIN-1:0] m_msk = '0, m_xen = '0, m_lvl = '0, m_pol = '0, m_pend = '0, m_prev = '0;

  task automatic chk(input string tag, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NPIN-1:0] m_events(input logic [NPIN-1:0] p);
    logic [NPIN-1:0] e;
    for (int i = 0; i < NPIN; i++) begin
      logic r, f;
      r = p[i] & ~m_prev[i];
      f = ~p[i] & m_prev[i];
      if (!m_xen[i])     e[i] = r | f;                      // R2
      else if (m_lvl[i]) e[i] = m_pol[i] ? p[i] : ~p[i];    // R8
      else               e[i] = m_pol[i] ? r : f;           // R7
    end
    return e;
  endfunction

  function automatic logic [NPIN-1:0] m_read(input logic [7:0] a);
    case (a)
      8'h48: return m_msk;
      8'h4c: return m_pend;
      8'hb8: return m_xen;
      8'hc8: return m_lvl;
      8'hd8: return m_pol;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h48: return "R3";
      8'h4c: return "R9";
      8'hb8: return "R4";
      8'hc8: return "R5";
      8'hd8: return "R6";
      default: return "R11";
    endcase
  endfunction

  // one clock: drive at negedge, model the edge, compare after it
  task automatic cyc(input logic [NPIN-1:0] p, input bit wr, input bit rd,
                     input logic [7:0] a, input logic [NPIN-1:0] wd, input string tag);
    logic [NPIN-1:0] ev, exp_rd, n_pend;
    logic exp_irq;
    @(negedge clk);
    pin_i = p; wr_en_i = wr; rd_en_i = rd; addr_i = a; wr_data_i = wd;
    ev      = m_events(p);
    exp_rd  = rd ? m_read(a) : '0;
    exp_irq = |(m_pend & m_msk);
    n_pend  = ((rd && a == 8'h4c) ? '0 : m_pend) | ev;
    @(posedge clk);
    #1;
    m_pend = n_pend;
    m_prev = p;
    if (wr) begin
      case (a)
        8'h40: m_msk = m_msk | wd;
        8'h44: m_msk = m_msk & ~wd;
        8'hb0: m_xen = m_xen | wd;
        8'hb4: m_xen = m_xen & ~wd;
        8'hc4: m_lvl = m_lvl | wd;
        8'hc0: m_lvl = m_lvl & ~wd;
        8'hd4: m_pol = m_pol | wd;
        8'hd0: m_pol = m_pol & ~wd;
        default: ;
      endcase
    end
    chk("R10 irq", {31'b0, irq_o}, {31'b0, exp_irq});
    if (rd) chk(tag == "" ? tag_of(a) : tag, rd_data_o, exp_rd);
  endtask

  task automatic wr(input logic [7:0] a, input logic [NPIN-1:0] wd);
    cyc(pin_i, 1'b1, 1'b0, a, wd, "");
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    cyc(pin_i, 1'b0, 1'b1, a, '0, tag);
  endtask
  task automatic idle(input logic [NPIN-1:0] p);
    cyc(p, 1'b0, 1'b0, 8'h00, '0, "");
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    void'($urandom(32'd715));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset values of every readable location and the outputs
    chk("R1 irq", {31'b0, irq_o}, '0);
    chk("R1 rdata", rd_data_o, '0);
    rd(8'h48, "R1"); rd(8'h4c, "R1"); rd(8'hb8, "R1"); rd(8'hc8, "R1"); rd(8'hd8, "R1");

    // R3: mask set/clear
    wr(8'h40, 32'h0000_00f0); rd(8'h48, "R3");
    wr(8'h44, 32'h0000_0030); rd(8'h48, "R3");
    wr(8'h44, '1);            rd(8'h48, "R3");
    wr(8'h40, '1);

    // R2: default mode catches both edges on pin 3
    idle(32'h8); idle(32'h8); rd(8'h4c, "R2");
    idle(32'h0); rd(8'h4c, "R2");
    // R11: a read of another location does not clear pending; write-only reads zero
    idle(32'h8); rd(8'h48, "R11"); rd(8'h40, "R11"); rd(8'h10, "R11"); rd(8'h4c, "R11");

    // R4/R6/R7: pin 5 rising only
    wr(8'hb0, 32'h20); wr(8'hd4, 32'h20); rd(8'hb8, "R4"); rd(8'hd8, "R6");
    idle(32'h28); rd(8'h4c, "R7");          // rising on 5, none on 3 (held high)
    idle(32'h08); rd(8'h4c, "R7");          // falling on 5 ignored
    wr(8'hd0, 32'h20); rd(8'hd8, "R6");     // now falling only
    idle(32'h28); rd(8'h4c, "R7");
    idle(32'h08); rd(8'h4c, "R7");

    // R5/R8: pin 6 level low, pin 7 level high
    wr(8'hb0, 32'hc0); wr(8'hc4, 32'hc0); wr(8'hd4, 32'h80); rd(8'hc8, "R5");
    rd(8'h4c, "R8"); rd(8'h4c, "R8"); rd(8'h4c, "R8");
    idle(32'hc8); rd(8'h4c, "R8"); rd(8'h4c, "R8");
    idle(32'h48); rd(8'h4c, "R8");
    wr(8'hc0, 32'hc0); rd(8'hc8, "R5");
    wr(8'hb4, '1); rd(8'hb8, "R4");
    rd(8'h4c, "R9");

    // R9: edge in the same cycle as the status read
    cyc(32'h48, 1'b0, 1'b1, 8'h4c, '0, "R9");
    cyc(32'h40, 1'b0, 1'b1, 8'h4c, '0, "R9");
    rd(8'h4c, "R9");

    // R10: masked pins still latch
    wr(8'h44, '1); idle(32'h41); idle(32'h41); idle(32'h41);
    wr(8'h40, 32'h1); idle(32'h41); idle(32'h41); rd(8'h4c, "R10");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] alist [14];
      logic [NPIN-1:0] p, wd;
      int k;
      alist = '{8'h40, 8'h44, 8'h48, 8'h4c, 8'hb0, 8'hb4, 8'hb8,
                8'hc0, 8'hc4, 8'hc8, 8'hd0, 8'hd4, 8'hd8, 8'h2c};
      p  = pin_i ^ ($urandom & $urandom & $urandom);
      wd = $urandom & $urandom;
      k  = $urandom_range(0, 13);
      case ($urandom_range(0, 3))
        0: cyc(p, 1'b1, 1'b0, alist[k], wd, "");
        1: cyc(p, 1'b0, 1'b1, alist[k], '0, "");
        2: cyc(p, 1'b0, 1'b1, 8'h4c, '0, "");
        default: cyc(p, 1'b0, 1'b0, 8'h00, '0, "");
      endcase
    end

    finished = 1;
    report();
  end
endmodule